// File: doc/BRIEF.md
# Event-Triggered Serial Sample Frame Reader

This block is the host side of a serial link to a multi-channel converter that pulses a "conversion ready" line every time a fresh set of results exists. The converter keeps pulsing that line no matter what the host wants, so the reader decides for itself which pulses to act on. It acts only when streaming is enabled and no earlier frame is still in flight. On each accepted pulse it takes a timestamp from a free-running counter. It then runs one serial burst: a single read-command byte goes out, followed by zero fill, while one big-endian 32-bit word per channel comes back.

After the burst the reader splits each channel word. The upper three bytes form a signed 24-bit result, which is sign-extended to the output width. The lowest byte is a status byte and is passed out on its own. Channels leave one at a time on a valid/ready stream, in ascending channel order, each tagged with its index and with the frame timestamp. A pulse that arrives while the reader is busy does not restart anything; it only increments a saturating overrun counter. The reader counts as busy from the accepted pulse until the last channel has been taken.

Top module: `sample_burst_reader`

## Requirements
- R1: While reset is held and just after it is released, chip select is high (inactive), the serial clock and serial data-out are low, the output stream is not valid and the overrun count is zero.
- R2: An accepted event produces exactly one chip-select-low window, and chip select stays low throughout it. The window contains exactly N_CH*WORD_BYTES*8 (256) rising serial-clock edges, each high and low phase lasting HALF_DIV clock cycles. The serial clock idles low, input data is sampled on its rising edge, output data changes on its falling edge, and chip select falls on the third clock edge after the event line rises.
- R3: The first byte sent is 0x80, most significant bit first. Every later byte of the burst is 0x00, and serial data-out is low whenever chip select is high.
- R4: For channel c, received byte 4c is the most significant byte of its word. The sample output is word bits [31:8] sign-extended to SAMPLE_W bits, and the status output is word bits [7:0].
- R5: Samples are offered only after chip select has returned high. Channel indices come out 0,1,...,N_CH-1 in that order, one per accepted handshake.
- R6: While valid is high and ready is low, valid, channel, sample, status and timestamp all hold their values.
- R7: The timestamp counter resets to 0 and increments every clock. Every sample of a frame carries the counter value that was current when the event line rose, plus 2.
- R8: While stream enable is low, rising events start no transfer, produce no output and leave the overrun count unchanged.
- R9: An enabled event during a burst, or while samples are still waiting to drain, increments the overrun count, which saturates at 2^OVR_W-1. It starts no second chip-select window and adds no extra samples.
- R10: Once the last channel has been taken, valid drops and the next enabled event starts a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stream_en | input | 1 | Accept conversion-ready events when high |
| conv_ready | input | 1 | Asynchronous conversion-ready pulse from the converter |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the converter |
| spi_miso | input | 1 | Serial data from the converter |
| smp_valid | output | 1 | Output sample valid |
| smp_ready | input | 1 | Output sample accepted by the consumer |
| smp_chan | output | $clog2(N_CH) | Channel index of the sample |
| smp_data | output | SAMPLE_W | Sign-extended 24-bit result |
| smp_status | output | 8 | Status byte of the channel word |
| smp_stamp | output | STAMP_W | Timestamp of the frame |
| overrun_cnt | output | OVR_W | Saturating count of events dropped while busy |

## Verification
Chip select falls on the third clock edge after the event line rises, and the timestamp equals the bench's own reset-aligned cycle count at the moment it drove the line, plus two. Serial edges come every HALF_DIV cycles, and a slave model in the bench changes its data bit on each falling serial edge, so the reader samples that bit at least one full phase later. Samples become valid on the same edge that raises chip select. The bench inspects outputs on falling clock edges, sets ready there, and counts a sample as taken only when valid and ready were both high across the following rising edge. A sample held back by ready must read identically at the next falling edge, and each overrun and "ignored" check reads the counters and the chip-select fall count only after the burst it could have disturbed has finished.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
    localparam int BYTE_W = 8;
    localparam logic [7:0] READ_CMD = 8'h80;

    typedef enum logic [1:0] {
        CTL_IDLE  = 2'd0,
        CTL_BURST = 2'd1,
        CTL_DRAIN = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/sbr_edge_sync.sv
module sbr_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    typedef struct packed {
        logic meta;
        logic sync;
        logic last;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d      = q;
        d.meta = async_in;
        d.sync = q.meta;
        d.last = q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rise = q.sync & ~q.last;
endmodule

// File: rtl/sbr_spi_burst.sv
module sbr_spi_burst #(
    parameter int          HALF_DIV = 2,
    parameter int          N_BYTES  = 32,
    parameter logic [7:0]  CMD      = 8'h80,
    localparam int         BIT_W    = $clog2(N_BYTES * 8),
    localparam int         IDX_W    = $clog2(N_BYTES),
    localparam int         DIV_W    = $clog2(HALF_DIV + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             miso,
    output logic             sclk,
    output logic             cs_n,
    output logic             mosi,
    output logic             byte_vld,
    output logic [7:0]       byte_data,
    output logic [IDX_W-1:0] byte_idx,
    output logic             done
);
    localparam int N_BITS = N_BYTES * 8;

    typedef struct packed {
        logic             active;
        logic             sclk;
        logic             mosi;
        logic [DIV_W-1:0] div_cnt;
        logic [BIT_W-1:0] bit_cnt;
        logic [6:0]       shreg;
    } spi_t;

    spi_t d, q;

    function automatic logic tx_bit(input logic [BIT_W-1:0] n);
        if (n < BIT_W'(8)) return CMD[3'd7 - n[2:0]];
        return 1'b0;
    endfunction

    always_comb begin
        d         = q;
        byte_vld  = 1'b0;
        byte_data = {q.shreg, miso};
        done      = 1'b0;
        if (!q.active) begin
            if (start) begin
                d.active  = 1'b1;
                d.sclk    = 1'b0;
                d.div_cnt = '0;
                d.bit_cnt = '0;
                d.mosi    = tx_bit('0);
            end
        end else if (q.div_cnt == DIV_W'(HALF_DIV - 1)) begin
            d.div_cnt = '0;
            if (!q.sclk) begin
                d.sclk  = 1'b1;
                d.shreg = {q.shreg[5:0], miso};
                if (q.bit_cnt[2:0] == 3'd7) byte_vld = 1'b1;
            end else begin
                d.sclk = 1'b0;
                if (q.bit_cnt == BIT_W'(N_BITS - 1)) begin
                    d.active = 1'b0;
                    d.mosi   = 1'b0;
                    done     = 1'b1;
                end else begin
                    d.bit_cnt = q.bit_cnt + 1'b1;
                    d.mosi    = tx_bit(q.bit_cnt + 1'b1);
                end
            end
        end else begin
            d.div_cnt = q.div_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sclk     = q.sclk;
    assign cs_n     = ~q.active;
    assign mosi     = q.mosi;
    assign byte_idx = q.bit_cnt[BIT_W-1:3];
endmodule

// File: rtl/sbr_frame_buf.sv
module sbr_frame_buf #(
    parameter int  N_CH       = 8,
    parameter int  WORD_BYTES = 4,
    parameter int  SAMPLE_W   = 32,
    localparam int N_BYTES    = N_CH * WORD_BYTES,
    localparam int IDX_W      = $clog2(N_BYTES),
    localparam int CH_W       = $clog2(N_CH),
    localparam int WORD_W     = WORD_BYTES * 8,
    localparam int RAW_W      = WORD_W - 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                byte_vld,
    input  logic [7:0]          byte_data,
    input  logic [IDX_W-1:0]    byte_idx,
    input  logic                load,
    input  logic                out_ready,
    output logic                out_valid,
    output logic [CH_W-1:0]     out_chan,
    output logic [SAMPLE_W-1:0] out_data,
    output logic [7:0]          out_status,
    output logic                drained
);
    typedef struct packed {
        logic [N_BYTES-1:0][7:0] bytes;
        logic                    valid;
        logic [CH_W-1:0]         chan;
    } buf_t;

    buf_t d, q;
    logic [N_CH-1:0][WORD_W-1:0] word_w;
    logic [WORD_W-1:0]           cur_word;
    logic [RAW_W-1:0]            raw;

    for (genvar c = 0; c < N_CH; c++) begin : g_word
        for (genvar k = 0; k < WORD_BYTES; k++) begin : g_lane
            assign word_w[c][(WORD_BYTES-1-k)*8 +: 8] = q.bytes[c*WORD_BYTES + k];
        end
    end

    always_comb begin
        d       = q;
        drained = 1'b0;
        if (byte_vld) d.bytes[byte_idx] = byte_data;
        if (load) begin
            d.valid = 1'b1;
            d.chan  = '0;
        end else if (q.valid && out_ready) begin
            if (q.chan == CH_W'(N_CH - 1)) begin
                d.valid = 1'b0;
                drained = 1'b1;
            end else begin
                d.chan = q.chan + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cur_word   = word_w[q.chan];
    assign raw        = cur_word[WORD_W-1:8];
    assign out_valid  = q.valid;
    assign out_chan   = q.chan;
    assign out_data   = {{(SAMPLE_W-RAW_W){raw[RAW_W-1]}}, raw};
    assign out_status = cur_word[7:0];
endmodule

// File: rtl/sample_burst_reader.sv
module sample_burst_reader #(
    parameter int  N_CH       = 8,
    parameter int  WORD_BYTES = 4,
    parameter int  HALF_DIV   = 2,
    parameter int  SAMPLE_W   = 32,
    parameter int  STAMP_W    = 32,
    parameter int  OVR_W      = 8,
    localparam int N_BYTES    = N_CH * WORD_BYTES,
    localparam int IDX_W      = $clog2(N_BYTES),
    localparam int CH_W       = $clog2(N_CH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stream_en,
    input  logic                conv_ready,
    output logic                spi_sclk,
    output logic                spi_cs_n,
    output logic                spi_mosi,
    input  logic                spi_miso,
    output logic                smp_valid,
    input  logic                smp_ready,
    output logic [CH_W-1:0]     smp_chan,
    output logic [SAMPLE_W-1:0] smp_data,
    output logic [7:0]          smp_status,
    output logic [STAMP_W-1:0]  smp_stamp,
    output logic [OVR_W-1:0]    overrun_cnt
);
    import sbr_pkg::*;

    typedef struct packed {
        ctl_state_e         state;
        logic [STAMP_W-1:0] stamp_cnt;
        logic [STAMP_W-1:0] stamp_lat;
        logic [OVR_W-1:0]   ovr;
    } ctl_t;

    ctl_t d, q;

    logic             evt_rise;
    logic             accept;
    logic             burst_done;
    logic             drained;
    logic             byte_vld;
    logic [7:0]       byte_data;
    logic [IDX_W-1:0] byte_idx;

    sbr_edge_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (conv_ready),
        .rise     (evt_rise)
    );

    always_comb begin
        d           = q;
        accept      = 1'b0;
        d.stamp_cnt = q.stamp_cnt + 1'b1;
        if (evt_rise && stream_en) begin
            if (q.state == CTL_IDLE) begin
                accept      = 1'b1;
                d.stamp_lat = q.stamp_cnt;
                d.state     = CTL_BURST;
            end else if (q.ovr != {OVR_W{1'b1}}) begin
                d.ovr = q.ovr + 1'b1;
            end
        end
        case (q.state)
            CTL_BURST: if (burst_done) d.state = CTL_DRAIN;
            CTL_DRAIN: if (drained)    d.state = CTL_IDLE;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= CTL_IDLE;
        end else begin
            q <= d;
        end
    end

    sbr_spi_burst #(
        .HALF_DIV (HALF_DIV),
        .N_BYTES  (N_BYTES),
        .CMD      (READ_CMD)
    ) u_spi (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .miso      (spi_miso),
        .sclk      (spi_sclk),
        .cs_n      (spi_cs_n),
        .mosi      (spi_mosi),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .byte_idx  (byte_idx),
        .done      (burst_done)
    );

    sbr_frame_buf #(
        .N_CH       (N_CH),
        .WORD_BYTES (WORD_BYTES),
        .SAMPLE_W   (SAMPLE_W)
    ) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_vld   (byte_vld),
        .byte_data  (byte_data),
        .byte_idx   (byte_idx),
        .load       (burst_done),
        .out_ready  (smp_ready),
        .out_valid  (smp_valid),
        .out_chan   (smp_chan),
        .out_data   (smp_data),
        .out_status (smp_status),
        .drained    (drained)
    );

    assign smp_stamp   = q.stamp_lat;
    assign overrun_cnt = q.ovr;
endmodule

// File: rtl/sbr_checker.sv
module sbr_checker #(
    parameter int N_CH     = 8,
    parameter int CH_W     = 3,
    parameter int SAMPLE_W = 32,
    parameter int STAMP_W  = 32,
    parameter int OVR_W    = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                spi_sclk,
    input logic                spi_cs_n,
    input logic                spi_mosi,
    input logic                smp_valid,
    input logic                smp_ready,
    input logic [CH_W-1:0]     smp_chan,
    input logic [SAMPLE_W-1:0] smp_data,
    input logic [7:0]          smp_status,
    input logic [STAMP_W-1:0]  smp_stamp,
    input logic [OVR_W-1:0]    overrun_cnt
);
    // R2
    idle_sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    // R3
    idle_mosi_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_mosi);

    // R5
    out_after_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> spi_cs_n);

    // R5
    chan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_ready && smp_chan != CH_W'(N_CH - 1))
        |=> (smp_valid && smp_chan == $past(smp_chan) + 1'b1));

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !smp_ready)
        |=> (smp_valid && $stable(smp_chan) && $stable(smp_data)
             && $stable(smp_status) && $stable(smp_stamp)));

    // R9
    ovr_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (overrun_cnt >= $past(overrun_cnt)));
endmodule

bind sample_burst_reader sbr_checker #(
    .N_CH     (N_CH),
    .CH_W     (CH_W),
    .SAMPLE_W (SAMPLE_W),
    .STAMP_W  (STAMP_W),
    .OVR_W    (OVR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_sclk    (spi_sclk),
    .spi_cs_n    (spi_cs_n),
    .spi_mosi    (spi_mosi),
    .smp_valid   (smp_valid),
    .smp_ready   (smp_ready),
    .smp_chan    (smp_chan),
    .smp_data    (smp_data),
    .smp_status  (smp_status),
    .smp_stamp   (smp_stamp),
    .overrun_cnt (overrun_cnt)
);

// File: tb/sample_burst_reader_tb.sv
module sample_burst_reader_tb;
    localparam int N_CH = 8;
    localparam int WB   = 4;
    localparam int NB   = N_CH * WB;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stream_en = 1'b0;
    logic        conv_ready = 1'b0;
    logic        spi_sclk, spi_cs_n, spi_mosi;
    logic        spi_miso = 1'b0;
    logic        smp_valid;
    logic        smp_ready = 1'b0;
    logic [2:0]  smp_chan;
    logic [31:0] smp_data;
    logic [7:0]  smp_status;
    logic [31:0] smp_stamp;
    logic [7:0]  overrun_cnt;

    always #4 clk = ~clk;

    sample_burst_reader u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .stream_en   (stream_en),
        .conv_ready  (conv_ready),
        .spi_sclk    (spi_sclk),
        .spi_cs_n    (spi_cs_n),
        .spi_mosi    (spi_mosi),
        .spi_miso    (spi_miso),
        .smp_valid   (smp_valid),
        .smp_ready   (smp_ready),
        .smp_chan    (smp_chan),
        .smp_data    (smp_data),
        .smp_status  (smp_status),
        .smp_stamp   (smp_stamp),
        .overrun_cnt (overrun_cnt)
    );

    int nvec = 0;
    int nerr = 0;
    bit finished = 1'b0;

    logic [31:0] bcnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bcnt <= '0;
        else        bcnt <= bcnt + 1'b1;
    end

    logic [7:0] frame_bytes [NB];
    logic [7:0] mosi_bytes  [NB];
    logic [7:0] mosi_sh;
    int sidx = 0;
    int rise_cnt = 0;
    int cs_falls = 0;

    always @(negedge spi_cs_n) begin
        if (rst_n) begin
            cs_falls = cs_falls + 1;
            sidx     = 0;
            rise_cnt = 0;
            spi_miso = frame_bytes[0][7];
        end
    end

    always @(negedge spi_sclk) begin
        if (rst_n && !spi_cs_n) begin
            sidx = sidx + 1;
            if (sidx < NB * 8) spi_miso = frame_bytes[sidx / 8][7 - (sidx % 8)];
        end
    end

    always @(posedge spi_sclk) begin
        if (rst_n && !spi_cs_n) begin
            mosi_sh  = {mosi_sh[6:0], spi_mosi};
            rise_cnt = rise_cnt + 1;
            if (rise_cnt % 8 == 0 && rise_cnt <= NB * 8) mosi_bytes[rise_cnt / 8 - 1] = mosi_sh;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nvec++;
        nerr++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    task automatic pulse(output logic [31:0] stamp);
        @(negedge clk);
        conv_ready = 1'b1;
        stamp = bcnt + 32'd2;
        repeat (3) @(negedge clk);
        conv_ready = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [31:0] exp_sample(input int c);
        return {{8{frame_bytes[c*WB][7]}}, frame_bytes[c*WB],
                frame_bytes[c*WB+1], frame_bytes[c*WB+2]};
    endfunction

    task automatic wait_burst_end();
        int g = 0;
        while (!spi_cs_n && g < 20000) begin
            @(negedge clk);
            g++;
        end
    endtask

    task automatic consume(input logic [31:0] exp_stamp, input int ready_pct);
        int got = 0;
        int g = 0;
        bit hold = 1'b0;
        logic [2:0]  h_chan;
        logic [31:0] h_data;
        logic [7:0]  h_stat;
        while (got < N_CH && g < 5000) begin
            bit r;
            @(negedge clk);
            g++;
            if (hold) begin
                // R6: held sample unchanged
                chk(smp_valid && smp_chan == h_chan && smp_data == h_data &&
                    smp_status == h_stat, "R6 hold", {smp_chan, smp_data},
                    {h_chan, h_data});
            end
            r = ($urandom % 100) < ready_pct;
            if (smp_valid) begin
                if (r) begin
                    // R5 order, R4 data, R7 stamp
                    chk(smp_chan == 3'(got), "R5 chan order", 64'(smp_chan), 64'(got));
                    chk(smp_data == exp_sample(got), "R4 sample", 64'(smp_data),
                        64'(exp_sample(got)));
                    chk(smp_status == frame_bytes[got*WB+3], "R4 status",
                        64'(smp_status), 64'(frame_bytes[got*WB+3]));
                    chk(smp_stamp == exp_stamp, "R7 stamp", 64'(smp_stamp),
                        64'(exp_stamp));
                    got++;
                end
                hold   = !r;
                h_chan = smp_chan;
                h_data = smp_data;
                h_stat = smp_status;
            end else begin
                hold = 1'b0;
            end
            smp_ready = r;
        end
        @(negedge clk);
        smp_ready = 1'b0;
        // R10: valid drops after the last channel
        chk(!smp_valid && got == N_CH, "R10 drained", {31'd0, smp_valid, 32'(got)},
            64'(N_CH));
    endtask

    // mode 0 plain, 1 extra event mid-burst, 2 extra event while draining,
    // 3 many events while draining (saturation)
    task automatic run_frame(input int mode, input int ready_pct);
        logic [31:0] st, junk;
        int falls0;
        int ovr0;
        int exp_ovr;
        bit zero_ok = 1'b1;
        falls0 = cs_falls;
        ovr0   = int'(overrun_cnt);
        pulse(st);
        if (mode == 1) begin
            repeat (40) @(negedge clk);
            pulse(junk);
        end
        wait_burst_end();
        if (mode == 2) pulse(junk);
        if (mode == 3) for (int i = 0; i < 260; i++) pulse(junk);
        // R2
        chk(cs_falls - falls0 == 1, "R2 one cs window", 64'(cs_falls - falls0), 64'd1);
        chk(rise_cnt == NB * 8, "R2 sclk edges", 64'(rise_cnt), 64'(NB * 8));
        // R3
        chk(mosi_bytes[0] == 8'h80, "R3 command byte", 64'(mosi_bytes[0]), 64'h80);
        for (int i = 1; i < NB; i++) if (mosi_bytes[i] != 8'h00) zero_ok = 1'b0;
        chk(zero_ok, "R3 zero fill", 64'(zero_ok), 64'd1);
        exp_ovr = ovr0 + ((mode == 1 || mode == 2) ? 1 : (mode == 3 ? 260 : 0));
        if (exp_ovr > 255) exp_ovr = 255;
        // R9
        chk(int'(overrun_cnt) == exp_ovr, "R9 overrun", 64'(overrun_cnt), 64'(exp_ovr));
        consume(st, ready_pct);
    endtask

    initial begin
        int falls0;
        int ovr0;
        logic [31:0] junk;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NB; i++) frame_bytes[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(spi_cs_n && !spi_sclk && !spi_mosi && !smp_valid && overrun_cnt == 0,
            "R1 reset", {spi_cs_n, spi_sclk, spi_mosi, smp_valid, overrun_cnt},
            {1'b1, 3'b000, 8'd0});
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(spi_cs_n && !spi_sclk && !spi_mosi && !smp_valid && overrun_cnt == 0,
            "R1 after reset", {spi_cs_n, spi_sclk, spi_mosi, smp_valid, overrun_cnt},
            {1'b1, 3'b000, 8'd0});
        stream_en = 1'b1;

        // R4 corners: max positive, min negative, -1, zero, +1, -2
        {frame_bytes[0],  frame_bytes[1],  frame_bytes[2],  frame_bytes[3]}  = 32'h7FFFFFA5;
        {frame_bytes[4],  frame_bytes[5],  frame_bytes[6],  frame_bytes[7]}  = 32'h8000005A;
        {frame_bytes[8],  frame_bytes[9],  frame_bytes[10], frame_bytes[11]} = 32'hFFFFFF01;
        {frame_bytes[12], frame_bytes[13], frame_bytes[14], frame_bytes[15]} = 32'h000000FF;
        {frame_bytes[16], frame_bytes[17], frame_bytes[18], frame_bytes[19]} = 32'h00000100;
        {frame_bytes[20], frame_bytes[21], frame_bytes[22], frame_bytes[23]} = 32'hFFFFFE80;
        {frame_bytes[24], frame_bytes[25], frame_bytes[26], frame_bytes[27]} = 32'h12345678;
        {frame_bytes[28], frame_bytes[29], frame_bytes[30], frame_bytes[31]} = 32'h8000013C;
        run_frame(0, 100);

        for (int f = 0; f < 12; f++) begin
            for (int i = 0; i < NB; i++) frame_bytes[i] = 8'($urandom);
            run_frame(f % 3, 30 + 20 * (f % 4));
        end

        // R8: disabled events are ignored
        stream_en = 1'b0;
        falls0 = cs_falls;
        ovr0   = int'(overrun_cnt);
        pulse(junk);
        repeat (30) @(negedge clk);
        chk(cs_falls == falls0 && spi_cs_n, "R8 no transfer", 64'(cs_falls), 64'(falls0));
        chk(!smp_valid, "R8 no output", 64'(smp_valid), 64'd0);
        chk(int'(overrun_cnt) == ovr0, "R8 no overrun", 64'(overrun_cnt), 64'(ovr0));
        stream_en = 1'b1;

        for (int i = 0; i < NB; i++) frame_bytes[i] = 8'($urandom);
        run_frame(0, 60);

        // R9 saturation
        for (int i = 0; i < NB; i++) frame_bytes[i] = 8'($urandom);
        run_frame(3, 50);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule